// File: doc/BRIEF.md
# Parallel ROM Read-Cycle Controller

This block carries out single-byte reads from an asynchronous parallel read-only memory for a synchronous host. The host offers an address with a valid/ready handshake. The controller then drops the device select and holds the address steady. It lowers the output-enable strobe at the point that lets all three access limits expire together: address-to-data, select-to-data and output-enable-to-data. It captures the byte at the end of the cycle in which the slowest of those limits has run out.

After the capture, both strobes return high and the device drops back into its low-power standby. The controller waits for the memory's output float time before it accepts the next request, so two accesses never fight over the data bus. All four timing limits arrive as cycle counts on configuration inputs. Each count is the nanosecond figure rounded up to whole clock periods. At a 5 ns clock, a 100 ns part uses 20/20/10/6.

Top module: `rom_read_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `mem_ce_n` and `mem_oe_n` are 1, `req_ready` is 1 and `done` is 0.
- R2: `req_ready` is 1 only when neither strobe is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `mem_ce_n` is 0 in the next cycle.
- R3: `mem_addr` takes the accepted `req_addr` when the select falls, and it does not change while `mem_ce_n` stays low.
- R4: `mem_oe_n` is low only while `mem_ce_n` is low. It falls D cycles after the select falls, where D = max(acc, ce) − oe, or 0 when that is negative. It then stays low until the select rises.
- R5: The select stays low for exactly S cycles, where S = max(acc, ce, oe, 1). The byte on `mem_data` is captured at the edge that ends the S-th cycle. `done` is then 1 for exactly one cycle, with `done_data` equal to that byte.
- R6: After the select rises, both strobes stay high for at least `cfg_t_float` cycles before the select falls again. `req_ready` stays 0 during that wait.
- R7: With all four timing counts at 0, an access lasts one cycle with both strobes low. It still returns the addressed byte.
- R8: Reads offered back to back are served in order, each returning the byte of its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_t_acc | input | CW | Address-to-data time, cycles |
| cfg_t_ce | input | CW | Select-to-data time, cycles |
| cfg_t_oe | input | CW | Output-enable-to-data time, cycles |
| cfg_t_float | input | CW | Float time after the strobes rise, cycles |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW | Byte address of the request |
| req_ready | output | 1 | Controller can take a request |
| done | output | 1 | One-cycle pulse: byte captured |
| done_data | output | DW | Captured byte |
| mem_addr | output | AW | Address bus to the memory |
| mem_ce_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_data | input | DW | Data bus from the memory |

## Verification
The checks assume that the four timing counts change only while the controller is idle with no request pending. They also assume that a request, once raised, keeps its address until it is accepted. The stimulus follows both rules. It reprograms the counts only after the scoreboard has drained and `req_ready` is high, and it holds each request until the handshake completes. The bench's memory model returns a wrong byte whenever any of the three access limits is not yet met at the capture edge. A capture taken too early therefore shows up as a data mismatch.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rrc_state_e;
endpackage

// File: rtl/rrc_timing.sv
// Derives the output-enable delay, the capture cycle and the float length
// from the programmed access counts.
module rrc_timing #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] t_acc,
  input  logic [CW-1:0] t_ce,
  input  logic [CW-1:0] t_oe,
  input  logic [CW-1:0] t_float,
  output logic [CW-1:0] oe_delay,
  output logic [CW-1:0] cap_last,
  output logic [CW-1:0] flt_last
);
  logic [CW-1:0] sel_max;
  logic [CW-1:0] span;

  always_comb begin
    sel_max  = (t_acc > t_ce) ? t_acc : t_ce;
    oe_delay = (sel_max > t_oe) ? (sel_max - t_oe) : '0;
    span     = (sel_max > t_oe) ? sel_max : t_oe;
    cap_last = (span == '0) ? '0 : span - 1'b1;
    flt_last = (t_float == '0) ? '0 : t_float - 1'b1;
  end
endmodule

// File: rtl/rrc_seq.sv
// Access sequencer: idle, strobed access, float turnaround.
module rrc_seq
  import rrc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] oe_delay,
  input  logic [CW-1:0] cap_last,
  input  logic [CW-1:0] flt_last,
  output logic          accept,
  output logic          capture,
  output logic          ready,
  output logic          ce_n,
  output logic          oe_n
);
  rrc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_ACCESS;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_ACCESS: begin
        cnt_en = 1'b1;
        if (cnt_q >= cap_last) begin
          capture = 1'b1;
          state_d = ST_FLOAT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FLOAT: begin
        cnt_en = 1'b1;
        if (cnt_q >= flt_last) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    ready = (state_q == ST_IDLE);
    ce_n  = (state_q != ST_ACCESS);
    oe_n  = !((state_q == ST_ACCESS) && (cnt_q >= oe_delay));
  end
endmodule

// File: rtl/rrc_capture.sv
// Address hold register and data capture with completion pulse.
module rrc_capture #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_out,
  output logic          done,
  output logic [DW-1:0] data_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
    end else if (accept) begin
      addr_out <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
    end else if (capture) begin
      data_out <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= capture;
    end
  end
endmodule

// File: rtl/rom_read_ctrl.sv
module rom_read_ctrl #(
  parameter int AW = 18,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_t_acc,
  input  logic [CW-1:0] cfg_t_ce,
  input  logic [CW-1:0] cfg_t_oe,
  input  logic [CW-1:0] cfg_t_float,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data
);
  logic [CW-1:0] oe_delay, cap_last, flt_last;
  logic          accept, capture;

  rrc_timing #(.CW(CW)) u_timing (
    .t_acc    (cfg_t_acc),
    .t_ce     (cfg_t_ce),
    .t_oe     (cfg_t_oe),
    .t_float  (cfg_t_float),
    .oe_delay (oe_delay),
    .cap_last (cap_last),
    .flt_last (flt_last)
  );

  rrc_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .oe_delay  (oe_delay),
    .cap_last  (cap_last),
    .flt_last  (flt_last),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n)
  );

  rrc_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .addr_in  (req_addr),
    .data_in  (mem_data),
    .addr_out (mem_addr),
    .done     (done),
    .data_out (done_data)
  );
endmodule

// File: rtl/rom_read_ctrl_chk.sv
module rom_read_ctrl_chk #(
  parameter int AW = 18,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_t_float,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n
);
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '1;
    end else if (!mem_ce_n) begin
      gap_q <= '0;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n)); // R2
  AST_ACCEPT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_ce_n); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3
  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!mem_ce_n) && mem_ce_n)); // R5
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (gap_q >= cfg_t_float)); // R6
endmodule

bind rom_read_ctrl rom_read_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_t_float (cfg_t_float),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .mem_addr    (mem_addr),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n)
);

// File: tb/sim_rom_read_ctrl.sv
`timescale 1ns/1ps
module sim_rom_read_ctrl;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_acc = '0, cfg_ce = '0, cfg_oe = '0, cfg_flt = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, done;
  logic [DW-1:0] done_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n;
  logic [DW-1:0] mem_drv = 8'hEE;

  always #2.5 clk = ~clk;

  rom_read_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_t_acc(cfg_acc), .cfg_t_ce(cfg_ce), .cfg_t_oe(cfg_oe), .cfg_t_float(cfg_flt),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .done(done), .done_data(done_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_data(mem_drv)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  int exp_s = 1, exp_doe = 0;

  function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Memory model and monitor, evaluated mid-cycle.
  int ce_age = 0, oe_age = 0, addr_age = 0, hi_cnt = 100;
  int len_last = 0, doe_meas = -1;
  bit prev_ce_n = 1, prev_oe_n = 1, addr_moved = 0, ready_bad = 0;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_addr = mem_addr;
    end else begin
      if (!mem_ce_n) begin
        ce_age++;
        if (prev_ce_n) begin
          check(hi_cnt >= int'(cfg_flt), "R6 float gap", hi_cnt, int'(cfg_flt));
          hi_cnt = 0;
          addr_moved = 0;
        end else if (mem_addr != prev_addr) addr_moved = 1;
      end else begin
        if (!prev_ce_n) len_last = ce_age;
        ce_age = 0;
        if (hi_cnt < 100) hi_cnt++;
      end
      if (!mem_oe_n) begin
        if (prev_oe_n) doe_meas = ce_age - 1;
        oe_age++;
      end else oe_age = 0;
      addr_age = (mem_addr == prev_addr) ? addr_age + 1 : 1;
      if (req_ready && (!mem_ce_n || !mem_oe_n)) ready_bad = 1;
      if (!mem_ce_n && !mem_oe_n && addr_age >= int'(cfg_acc) &&
          ce_age >= int'(cfg_ce) && oe_age >= int'(cfg_oe))
        mem_drv = rom_byte(mem_addr);
      else
        mem_drv = 8'hEE;
      if (done) begin
        if (exp_q.size() == 0) check(0, "R8 unexpected done", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(done_data == e, "R5/R8 data", done_data, e);
        end
        check(len_last == exp_s, "R5/R7 select length", len_last, exp_s);
        check(doe_meas == exp_doe, "R4 oe delay", doe_meas, exp_doe);
        check(!addr_moved, "R3 address held", addr_moved, 0);
        check(!ready_bad, "R2 ready while strobed", ready_bad, 0);
        ready_bad = 0;
        doe_meas = -1;
      end
      prev_ce_n = mem_ce_n;
      prev_oe_n = mem_oe_n;
      prev_addr = mem_addr;
    end
  end

  task automatic do_read(input logic [AW-1:0] a);
    exp_q.push_back(rom_byte(a));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input int a, input int c, input int o, input int f);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    cfg_acc = CW'(a); cfg_ce = CW'(c); cfg_oe = CW'(o); cfg_flt = CW'(f);
    exp_s = (a > c) ? a : c;
    exp_doe = (exp_s > o) ? exp_s - o : 0;
    if (o > exp_s) exp_s = o;
    if (exp_s < 1) exp_s = 1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (4) @(negedge clk);
    check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R1 strobes in reset", mem_ce_n, 1);
    check(done === 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R1 idle strobes", mem_oe_n, 1);

    set_cfg(20, 20, 10, 6);           // 100 ns grade at 5 ns clock
    do_read(18'h00123); do_read(18'h3F0AA); do_read(18'h15555);
    drain();
    set_cfg(2, 2, 5, 3);              // output enable dominates
    do_read(18'h00001); do_read(18'h2BEEF);
    drain();
    set_cfg(3, 7, 2, 0);              // select dominates, no float
    do_read(18'h10010); do_read(18'h0F00F);
    drain();
    set_cfg(0, 0, 0, 0);              // R7 zero counts
    do_read(18'h12345); do_read(18'h00ABC); do_read(18'h3FFFF);
    drain();
    set_cfg(9, 4, 3, 2);              // address dominates
    do_read(18'h0C0DE); do_read(18'h20202);
    drain();
    check(exp_q.size() == 0, "R8 all reads completed", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "R8 watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule